// File: doc/BRIEF.md
# Quadrature NCO and Single-Sideband Up-Converter

This block pairs a numerically controlled oscillator with a complex mixer. Each valid I/Q input pair advances a 32-bit phase accumulator by a programmable tuning word. The top ten bits of that phase, plus a 16-bit phase offset, address a sine/cosine table that is computed when the design is elaborated. The mixer then shifts the pair to the upper or lower sideband, optionally inverts the result, or passes the pair through untouched.

A low-power setting reduces both the tuning word and the offset to their five most significant bits. Deasserting the enable holds the oscillator phase at zero. Outputs are registered, rounded and saturated to the input width. They appear a fixed three cycles after the sample enters, together with a valid flag that follows the input valid.

Top module: `nco_ssb_mixer`

## Requirements
- R1: While and directly after `rst` is high, `out_valid` is 0 and `out_a`, `out_b` are 0.
- R2: `out_valid` equals `in_valid` from three clock edges earlier; the data on `out_a`/`out_b` belong to that same sample.
- R3: With `nco_en`=1, each sample taken with `in_valid`=1 adds `freq_word` to the accumulator after its own lookup. The first sample after reset uses phase 0. The table index is `acc[31:22] + phase_ofs[15:6]`, taken modulo 1024.
- R4: With `nco_en`=0 the accumulator is cleared, and the sample taken in that cycle uses accumulator value 0 (only the offset sets the index).
- R5: With `lowpwr`=1, bits 26..0 of `freq_word` and bits 10..0 of `phase_ofs` are treated as zero.
- R6: `mod_sel` values 000, 101, 110 and 111 select bypass: `out_a` = I and `out_b` = Q.
- R7: `mod_sel`=001 (upper sideband) gives A = I·c − Q·s and B = I·s + Q·c. Here s = round(8191·sin(2πk/1024)), c = s at index k+256, and k is the table index.
- R8: `mod_sel`=010 (lower sideband) gives A = I·c + Q·s and B = −I·s + Q·c.
- R9: `mod_sel`=011 and 100 give the negation of the 001 and 010 results. The negation is applied before rounding.
- R10: Each mixed sum x is reduced to floor((x + 4096) / 8192), then clipped to the range −8192..8191.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nco_en | input | 1 | Oscillator enable; 0 holds phase at zero |
| lowpwr | input | 1 | Use only five top bits of tuning word and offset |
| freq_word | input | 32 | Phase increment per sample |
| phase_ofs | input | 16 | Phase offset added before lookup |
| mod_sel | input | 3 | Mixing mode code |
| in_valid | input | 1 | Input sample valid |
| in_i | input | 14 | In-phase input sample, signed |
| in_q | input | 14 | Quadrature input sample, signed |
| out_valid | output | 1 | Output sample valid |
| out_a | output | 14 | Channel A output, signed |
| out_b | output | 14 | Channel B output, signed |

## Verification
The bench targets the full-scale corner where I and Q are both at an extreme and sine equals cosine. There the sum exceeds the output range, so a design without clipping would wrap to the opposite sign. A ramp of one table step per sample exposes an accumulator that updates before its own lookup (off by one index) and a wrong offset alignment. Disabled and low-power runs carry nonzero low bits, which a design that ignored the enable or the mask would leak into the phase. The unused mode codes and the negated modes are mixed into the random traffic, where a wrong sign or wrong mode decode shows up as a swapped or inverted channel.

// File: rtl/nco_pkg.sv
package nco_pkg;
  typedef struct packed {
    logic bypass;
    logic lower;
    logic negate;
  } mix_ctrl_t;

  function automatic mix_ctrl_t decode_mode(input logic [2:0] code);
    mix_ctrl_t c;
    c = '{bypass: 1'b1, lower: 1'b0, negate: 1'b0};
    case (code)
      3'd1: c = '{bypass: 1'b0, lower: 1'b0, negate: 1'b0};
      3'd2: c = '{bypass: 1'b0, lower: 1'b1, negate: 1'b0};
      3'd3: c = '{bypass: 1'b0, lower: 1'b0, negate: 1'b1};
      3'd4: c = '{bypass: 1'b0, lower: 1'b1, negate: 1'b1};
      default: c = '{bypass: 1'b1, lower: 1'b0, negate: 1'b0};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/nco_phase.sv
module nco_phase #(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 16,
  parameter int IDX_W   = 10,
  parameter int LP_BITS = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             lp,
  input  logic             valid,
  input  logic [ACC_W-1:0] fw,
  input  logic [PH_W-1:0]  ofs,
  output logic [ACC_W-1:0] acc,
  output logic [IDX_W-1:0] idx
);
  localparam logic [ACC_W-1:0] FW_MASK  = {{LP_BITS{1'b1}}, {(ACC_W-LP_BITS){1'b0}}};
  localparam logic [PH_W-1:0]  OFS_MASK = {{LP_BITS{1'b1}}, {(PH_W-LP_BITS){1'b0}}};

  logic [ACC_W-1:0] fw_eff, acc_use;
  logic [PH_W-1:0]  ofs_eff;

  always_comb begin
    fw_eff  = lp ? (fw & FW_MASK) : fw;
    ofs_eff = lp ? (ofs & OFS_MASK) : ofs;
    acc_use = en ? acc : '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !en) acc <= '0;
    else if (valid) acc <= acc + fw_eff;
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else     idx <= acc_use[ACC_W-1 -: IDX_W] + ofs_eff[PH_W-1 -: IDX_W];
  end
endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
  parameter int AW = 10,
  parameter int DW = 14
) (
  input  logic                 clk,
  input  logic [AW-1:0]        idx,
  output logic signed [DW-1:0] sin_q,
  output logic signed [DW-1:0] cos_q
);
  localparam int  DEPTH   = 1 << AW;
  localparam int  QUARTER = DEPTH / 4;
  localparam real AMP     = real'((1 << (DW-1)) - 1);
  localparam real TWO_PI  = 6.283185307179586;

  logic signed [DW-1:0] table_mem [DEPTH];
  logic [AW-1:0] cos_idx;

  initial begin
    for (int k = 0; k < DEPTH; k++)
      table_mem[k] = DW'($rtoi($floor(AMP * $sin(TWO_PI * real'(k) / real'(DEPTH)) + 0.5)));
  end

  assign cos_idx = idx + AW'(QUARTER);

  always_ff @(posedge clk) begin
    sin_q <= table_mem[idx];
    cos_q <= table_mem[cos_idx];
  end
endmodule

// File: rtl/nco_ssb_mix.sv
module nco_ssb_mix
  import nco_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 valid_in,
  input  mix_ctrl_t            ctrl,
  input  logic signed [DW-1:0] di,
  input  logic signed [DW-1:0] dq,
  input  logic signed [DW-1:0] s,
  input  logic signed [DW-1:0] c,
  output logic                 valid_out,
  output logic signed [DW-1:0] ya,
  output logic signed [DW-1:0] yb
);
  localparam int PW = 2*DW + 2;
  localparam int SH = DW - 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH-1);
  localparam logic signed [PW-1:0] MAXV = PW'((1 << (DW-1)) - 1);
  localparam logic signed [PW-1:0] MINV = -PW'(1 << (DW-1));

  logic signed [PW-1:0] ic, qs, is_, qc, sa, sb, ra, rb;

  function automatic logic signed [DW-1:0] clip(input logic signed [PW-1:0] v);
    if (v > MAXV) return MAXV[DW-1:0];
    if (v < MINV) return MINV[DW-1:0];
    return v[DW-1:0];
  endfunction

  always_comb begin
    ic  = di * c;
    qs  = dq * s;
    is_ = di * s;
    qc  = dq * c;
    sa  = ctrl.lower ? (ic + qs) : (ic - qs);
    sb  = ctrl.lower ? (qc - is_) : (qc + is_);
    if (ctrl.negate) begin
      sa = -sa;
      sb = -sb;
    end
    ra = (sa + HALF) >>> SH;
    rb = (sb + HALF) >>> SH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_out <= 1'b0;
      ya        <= '0;
      yb        <= '0;
    end else begin
      valid_out <= valid_in;
      ya        <= ctrl.bypass ? di : clip(ra);
      yb        <= ctrl.bypass ? dq : clip(rb);
    end
  end
endmodule

// File: rtl/nco_ssb_mixer.sv
module nco_ssb_mixer
  import nco_pkg::*;
#(
  parameter int ACC_W   = 32,
  parameter int PH_W    = 16,
  parameter int IDX_W   = 10,
  parameter int DW      = 14,
  parameter int LP_BITS = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 nco_en,
  input  logic                 lowpwr,
  input  logic [ACC_W-1:0]     freq_word,
  input  logic [PH_W-1:0]      phase_ofs,
  input  logic [2:0]           mod_sel,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_a,
  output logic signed [DW-1:0] out_b
);
  logic [ACC_W-1:0]     phase_acc;
  logic [IDX_W-1:0]     lut_idx;
  logic signed [DW-1:0] sin_v, cos_v;

  logic                 v1, v2;
  mix_ctrl_t            m1, m2;
  logic signed [DW-1:0] i1, q1, i2, q2;

  nco_phase #(.ACC_W(ACC_W), .PH_W(PH_W), .IDX_W(IDX_W), .LP_BITS(LP_BITS)) u_phase (
    .clk(clk), .rst(rst), .en(nco_en), .lp(lowpwr), .valid(in_valid),
    .fw(freq_word), .ofs(phase_ofs), .acc(phase_acc), .idx(lut_idx)
  );

  nco_sincos_rom #(.AW(IDX_W), .DW(DW)) u_rom (
    .clk(clk), .idx(lut_idx), .sin_q(sin_v), .cos_q(cos_v)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0;
      m1 <= '0;   m2 <= '0;
      i1 <= '0;   q1 <= '0;
      i2 <= '0;   q2 <= '0;
    end else begin
      v1 <= in_valid;
      m1 <= decode_mode(mod_sel);
      i1 <= in_i;
      q1 <= in_q;
      v2 <= v1;
      m2 <= m1;
      i2 <= i1;
      q2 <= q1;
    end
  end

  nco_ssb_mix #(.DW(DW)) u_mix (
    .clk(clk), .rst(rst), .valid_in(v2), .ctrl(m2),
    .di(i2), .dq(q2), .s(sin_v), .c(cos_v),
    .valid_out(out_valid), .ya(out_a), .yb(out_b)
  );
endmodule

// File: rtl/nco_ssb_checker.sv
module nco_ssb_checker
  import nco_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int DW    = 14
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 nco_en,
  input logic                 lowpwr,
  input logic                 in_valid,
  input logic [ACC_W-1:0]     freq_word,
  input logic [2:0]           mod_sel,
  input logic signed [DW-1:0] in_i,
  input logic [ACC_W-1:0]     acc,
  input logic                 out_valid,
  input logic signed [DW-1:0] out_a,
  input logic signed [DW-1:0] out_b
);
  logic [1:0] warm;
  logic       ready;

  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end
  assign ready = (warm == 2'd3);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && out_a == '0 && out_b == '0));

  p_valid_delay_r2: assert property (@(posedge clk) disable iff (rst)
    ready |-> (out_valid == $past(in_valid, 3)));

  p_acc_step_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(nco_en) && $past(in_valid) && !$past(lowpwr))
      |-> (acc == $past(acc) + $past(freq_word)));

  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(nco_en) && !$past(in_valid)) |-> $stable(acc));

  p_acc_zero_r4: assert property (@(posedge clk) disable iff (rst)
    !nco_en |=> (acc == '0));

  p_bypass_r6: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(in_valid, 3) && decode_mode($past(mod_sel, 3)).bypass)
      |-> (out_a == $past(in_i, 3)));
endmodule

bind nco_ssb_mixer nco_ssb_checker #(.ACC_W(ACC_W), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .nco_en(nco_en), .lowpwr(lowpwr), .in_valid(in_valid),
  .freq_word(freq_word), .mod_sel(mod_sel), .in_i(in_i), .acc(phase_acc),
  .out_valid(out_valid), .out_a(out_a), .out_b(out_b)
);

// File: tb/tb_nco_ssb_mixer.sv
module tb_nco_ssb_mixer;
  logic clk = 0;
  logic rst = 1;
  logic nco_en = 0, lowpwr = 0, in_valid = 0;
  logic [31:0] freq_word = 32'h2666_6666;
  logic [15:0] phase_ofs = 0;
  logic [2:0]  mod_sel = 0;
  logic signed [13:0] in_i = 0, in_q = 0;
  logic out_valid;
  logic signed [13:0] out_a, out_b;

  int errors = 0, checks = 0, cycles = 0;
  int sin_t [1024];
  logic [31:0] acc_m = 0;
  bit    pv [3];
  int    pa [3];
  int    pb [3];
  string pt [3];

  always #10 clk = ~clk;

  nco_ssb_mixer dut (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int sat(input longint v);
    longint r;
    r = (v + 4096) >>> 13;
    if (r > 8191) r = 8191;
    if (r < -8192) r = -8192;
    return int'(r);
  endfunction

  task automatic model(input logic [2:0] m, input int i, input int q, input int k,
                       output int a, output int b);
    longint s, c, x, y;
    s = sin_t[k];
    c = sin_t[(k + 256) % 1024];
    case (m)
      3'd1, 3'd3: begin x = i*c - q*s; y = i*s + q*c; end
      3'd2, 3'd4: begin x = i*c + q*s; y = q*c - i*s; end
      default: begin x = 0; y = 0; end
    endcase
    if (m == 3'd3 || m == 3'd4) begin x = -x; y = -y; end
    if (m == 0 || m > 4) begin a = i; b = q; end
    else begin a = sat(x); b = sat(y); end
  endtask

  function automatic string mtag(input logic [2:0] m);
    case (m)
      3'd1: return "R7";
      3'd2: return "R8";
      3'd3, 3'd4: return "R9";
      default: return "R6";
    endcase
  endfunction

  task automatic step(input bit v, input bit en, input bit lp, input logic [31:0] fw,
                      input logic [15:0] ofs, input logic [2:0] m,
                      input int i, input int q, input string tag);
    logic [31:0] fe, au;
    logic [15:0] oe;
    logic [9:0]  k;
    int a, b;
    @(negedge clk);
    chk("R2 valid", int'(out_valid), int'(pv[2]));
    if (pv[2]) begin
      chk({pt[2], " chA"}, int'(out_a), pa[2]);
      chk({pt[2], " chB"}, int'(out_b), pb[2]);
    end
    pv[2] = pv[1]; pa[2] = pa[1]; pb[2] = pb[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pa[1] = pa[0]; pb[1] = pb[0]; pt[1] = pt[0];
    in_valid = v; nco_en = en; lowpwr = lp; freq_word = fw; phase_ofs = ofs;
    mod_sel = m; in_i = 14'(i); in_q = 14'(q);
    fe = lp ? (fw & 32'hF800_0000) : fw;
    oe = lp ? (ofs & 16'hF800) : ofs;
    au = en ? acc_m : 32'd0;
    k  = au[31:22] + oe[15:6];
    model(m, i, q, int'(k), a, b);
    pv[0] = v; pa[0] = a; pb[0] = b; pt[0] = (tag == "") ? mtag(m) : tag;
    if (!en) acc_m = 0;
    else if (v) acc_m = acc_m + fe;
  endtask

  function automatic int rs14();
    return int'($signed(14'($urandom)));
  endfunction

  initial begin
    void'($urandom(32'd1405));
    for (int k = 0; k < 1024; k++)
      sin_t[k] = $rtoi($floor(8191.0 * $sin(6.283185307179586 * real'(k) / 1024.0) + 0.5));
    for (int n = 0; n < 3; n++) begin pv[n] = 0; pa[n] = 0; pb[n] = 0; pt[n] = "R2"; end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 valid", int'(out_valid), 0);
    chk("R1 chA", int'(out_a), 0);
    chk("R1 chB", int'(out_b), 0);

    // one table step per sample from phase zero
    for (int n = 0; n < 12; n++) step(1, 1, 0, 32'h0040_0000, 16'h0000, 3'd1, 5000, -3000, "R3");
    // offset alignment with gaps in valid
    for (int n = 0; n < 10; n++) step(n % 2, 1, 0, 32'h0123_4567, 16'h4AC0, 3'd2, 4000, 2500, "R3");
    // disabled: phase held, only offset matters
    for (int n = 0; n < 8; n++) step(1, 0, 0, 32'h3F00_1234, 16'h2000, 3'd1, 7000, 1000, "R4");
    // low-power masking of low bits
    for (int n = 0; n < 10; n++) step(1, 1, 1, 32'h0FFF_FFFF, 16'h07FF, 3'd1, 3000, 6000, "R5");
    for (int n = 0; n < 10; n++) step(1, 1, 1, 32'h2666_6666, 16'h1FC0, 3'd2, -4000, 2000, "R5");
    // saturation where sin = cos (index 128)
    step(1, 0, 0, 32'd0, 16'h2000, 3'd1, 8191, 8191, "R10");
    step(1, 0, 0, 32'd0, 16'h2000, 3'd1, -8192, -8192, "R10");
    step(1, 0, 0, 32'd0, 16'h2000, 3'd3, -8192, -8192, "R10");
    step(1, 0, 0, 32'd0, 16'h0000, 3'd4, -8192, 8191, "R10");
    // unused codes behave as bypass
    for (int m = 5; m < 8; m++) step(1, 1, 0, 32'h2666_6666, 16'h0, 3'(m), -8192, 8191, "R6");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] m;
      m = 3'($urandom_range(0, 7));
      step(($urandom % 4) != 0, ($urandom % 16) != 0, ($urandom % 8) == 0,
           (n < 1000) ? 32'h2666_6666 : $urandom, 16'($urandom), m, rs14(), rs14(), "");
    end
    for (int n = 0; n < 4; n++) step(0, 1, 0, 32'h2666_6666, 16'h0, 3'd0, 0, 0, "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule